// File: doc/BRIEF.md
# Pipelined Bitonic Key Sorter

This block sorts a vector of 2^LG_N unsigned keys, each KEY_W bits wide, into ascending order. The keys arrive side by side on one packed bus with a valid strobe. The sorted vector leaves on a second packed bus with its own valid strobe, a fixed number of cycles later. Element 0 sits in the most significant KEY_W bits of each bus. After sorting, it holds the smallest key.

The network is a chain of merge stages whose block width doubles from 2 up to 2^LG_N. A merge on blocks of width 2^s has s layers. The first layer folds each block onto itself: the k-th key from the front is compared with the k-th key from the back. Each of the remaining s-1 layers halves the block and compares keys that are half a block apart. A register follows every compare-exchange layer. The block therefore accepts a fresh vector on every clock and delivers results in the order they were accepted.

Top module: `bsort_top`

## Requirements
- R1: Whenever `out_valid` is high, `out_keys` is in ascending order. Element i occupies bits [KEY_W*(N-1-i) +: KEY_W], so element 0 (the most significant slice) holds the smallest key.
- R2: Each output vector holds exactly the same multiset of keys as its input vector, with duplicates kept.
- R3: A vector presented with `in_valid` high appears with `out_valid` high exactly LG_N*(LG_N+1)/2 clock cycles later. That is 10 cycles at the default LG_N=4.
- R4: With `in_valid` held high on consecutive cycles, one sorted vector leaves per cycle, in acceptance order.
- R5: `out_valid` is high only in cycles that correspond to an accepted input. Idle input cycles produce idle output cycles at the same spacing.
- R6: While `rst_n` is low, `out_valid` is low whatever `in_valid` does. Vectors offered during reset never emerge.
- R7: Keys compare as unsigned numbers, so a key with its top bit set sorts above every key with its top bit clear.
- R8: Inputs that are already ascending, fully descending, all equal, or full of repeated keys still come out correctly sorted.
- R9: `in_keys` is ignored in cycles where `in_valid` is low. Garbage there leaves the neighbouring accepted vectors' results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| in_valid | input | 1 | Marks `in_keys` as a vector to sort this cycle |
| in_keys | input | 2^LG_N*KEY_W | Packed unsorted keys, element 0 in the top slice |
| out_valid | output | 1 | Marks `out_keys` as a sorted result |
| out_keys | output | 2^LG_N*KEY_W | Packed sorted keys, smallest in the top slice |

## Verification
Random vectors check the general ordering and key conservation. Ascending, descending and all-equal vectors isolate the mirrored fold, the stride layers and the no-swap-on-equal rule, each of which a wrong comparator would expose differently. Keys mixing the top bit with small values separate unsigned from signed comparison, and low-range random keys force many duplicates. A long back-to-back stream and a gapped stream carrying garbage on idle cycles check throughput, ordering and valid spacing, and that idle data cannot leak into results.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

  // How a layer pairs the keys inside one block.
  typedef enum logic {
    PAIR_MIRROR = 1'b0,  // k-th from front against k-th from back
    PAIR_STRIDE = 1'b1   // keys half a block apart
  } pair_kind_e;

  // Total registered layers for a network of 2^lg keys.
  function automatic int layer_total(input int lg);
    return (lg * (lg + 1)) / 2;
  endfunction

endpackage

// File: rtl/bsort_cmpx.sv
// Single compare-exchange: the lower position receives the smaller key.
// Equal keys are left where they are.
module bsort_cmpx #(
  parameter int KEY_W = 32
) (
  input  logic [KEY_W-1:0] a_i,   // key bound for the lower position
  input  logic [KEY_W-1:0] b_i,   // key bound for the higher position
  output logic [KEY_W-1:0] lo_o,
  output logic [KEY_W-1:0] hi_o
);

  logic swap;

  always_comb begin
    swap = (a_i > b_i);
    lo_o = swap ? b_i : a_i;
    hi_o = swap ? a_i : b_i;
  end

endmodule

// File: rtl/bsort_layer.sv
// One compare-exchange layer followed by its pipeline register.
module bsort_layer
  import bsort_pkg::*;
#(
  parameter int         LG_N    = 4,
  parameter int         KEY_W   = 32,
  parameter int         SPAN_LG = 1,           // log2 of block width
  parameter pair_kind_e KIND    = PAIR_MIRROR
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_i,
  input  logic [(1<<LG_N)*KEY_W-1:0] d_i,
  output logic                    v_o,
  output logic [(1<<LG_N)*KEY_W-1:0] d_o
);

  localparam int N     = 1 << LG_N;
  localparam int PAIRS = N / 2;
  localparam int BLK   = 1 << SPAN_LG;
  localparam int HALF  = BLK / 2;

  logic [N*KEY_W-1:0] d_nxt;
  logic [N*KEY_W-1:0] d_q;
  logic               v_q;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int BI = p / HALF;
    localparam int K  = p % HALF;
    localparam int LO = BI * BLK + K;
    localparam int HI = (KIND == PAIR_MIRROR) ? (BI * BLK + BLK - 1 - K)
                                              : (LO + HALF);
    logic [KEY_W-1:0] lo_w;
    logic [KEY_W-1:0] hi_w;

    bsort_cmpx #(.KEY_W(KEY_W)) u_cx (
      .a_i  (d_i[KEY_W*(N-1-LO) +: KEY_W]),
      .b_i  (d_i[KEY_W*(N-1-HI) +: KEY_W]),
      .lo_o (lo_w),
      .hi_o (hi_w)
    );

    assign d_nxt[KEY_W*(N-1-LO) +: KEY_W] = lo_w;
    assign d_nxt[KEY_W*(N-1-HI) +: KEY_W] = hi_w;
  end

  // Data register: no reset, loads only when a vector is present.
  always_ff @(posedge clk) begin
    if (v_i) begin
      d_q <= d_nxt;
    end
  end

  // Valid register: cleared by reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= v_i;
    end
  end

  assign d_o = d_q;
  assign v_o = v_q;

endmodule

// File: rtl/bsort_merge.sv
// Merge stage on blocks of width 2^STAGE: one mirrored fold layer, then
// STAGE-1 stride layers on blocks that halve each time.
module bsort_merge
  import bsort_pkg::*;
#(
  parameter int LG_N  = 4,
  parameter int KEY_W = 32,
  parameter int STAGE = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_i,
  input  logic [(1<<LG_N)*KEY_W-1:0] d_i,
  output logic                    v_o,
  output logic [(1<<LG_N)*KEY_W-1:0] d_o
);

  localparam int NW = (1 << LG_N) * KEY_W;

  logic [NW-1:0] d_w [0:STAGE];
  logic          v_w [0:STAGE];

  assign d_w[0] = d_i;
  assign v_w[0] = v_i;

  for (genvar t = 0; t < STAGE; t++) begin : g_lyr
    localparam pair_kind_e KND = (t == 0) ? PAIR_MIRROR : PAIR_STRIDE;
    bsort_layer #(
      .LG_N    (LG_N),
      .KEY_W   (KEY_W),
      .SPAN_LG (STAGE - t),
      .KIND    (KND)
    ) u_layer (
      .clk   (clk),
      .rst_n (rst_n),
      .v_i   (v_w[t]),
      .d_i   (d_w[t]),
      .v_o   (v_w[t+1]),
      .d_o   (d_w[t+1])
    );
  end

  assign d_o = d_w[STAGE];
  assign v_o = v_w[STAGE];

endmodule

// File: rtl/bsort_top.sv
module bsort_top #(
  parameter int LG_N  = 4,
  parameter int KEY_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [(1<<LG_N)*KEY_W-1:0] in_keys,
  output logic                       out_valid,
  output logic [(1<<LG_N)*KEY_W-1:0] out_keys
);

  localparam int NW = (1 << LG_N) * KEY_W;

  logic [NW-1:0] d_s [0:LG_N];
  logic          v_s [0:LG_N];

  assign d_s[0] = in_keys;
  assign v_s[0] = in_valid;

  for (genvar s = 1; s <= LG_N; s++) begin : g_merge
    bsort_merge #(
      .LG_N  (LG_N),
      .KEY_W (KEY_W),
      .STAGE (s)
    ) u_merge (
      .clk   (clk),
      .rst_n (rst_n),
      .v_i   (v_s[s-1]),
      .d_i   (d_s[s-1]),
      .v_o   (v_s[s]),
      .d_o   (d_s[s])
    );
  end

  assign out_keys  = d_s[LG_N];
  assign out_valid = v_s[LG_N];

endmodule

// File: rtl/bsort_chk.sv
module bsort_chk #(
  parameter int LG_N  = 4,
  parameter int KEY_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic [(1<<LG_N)*KEY_W-1:0] in_keys,
  input logic                       out_valid,
  input logic [(1<<LG_N)*KEY_W-1:0] out_keys
);

  localparam int N   = 1 << LG_N;
  localparam int LAT = bsort_pkg::layer_total(LG_N);
  localparam int SW  = KEY_W + LG_N;

  function automatic logic [SW-1:0] key_sum(input logic [N*KEY_W-1:0] v);
    logic [SW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + SW'(v[KEY_W*i +: KEY_W]);
    return acc;
  endfunction

  function automatic logic is_ascending(input logic [N*KEY_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < N - 1; i++)
      if (v[KEY_W*(N-1-i) +: KEY_W] > v[KEY_W*(N-2-i) +: KEY_W]) ok = 1'b0;
    return ok;
  endfunction

  logic [SW-1:0] sum_pipe [0:LAT-1];
  logic [LAT-1:0] vld_pipe;
  logic [15:0]    inflight;

  always_ff @(posedge clk) begin
    sum_pipe[0] <= key_sum(in_keys);
    for (int j = 1; j < LAT; j++) sum_pipe[j] <= sum_pipe[j-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_pipe <= '0;
      inflight <= '0;
    end else begin
      vld_pipe <= {vld_pipe[LAT-2:0], in_valid};
      if (in_valid && !out_valid)      inflight <= inflight + 16'd1;
      else if (!in_valid && out_valid) inflight <= inflight - 16'd1;
    end
  end

  assert_sorted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> is_ascending(out_keys));

  assert_keysum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (key_sum(out_keys) == sum_pipe[LAT-1]));

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vld_pipe[LAT-1]);

  assert_inflight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight <= 16'(LAT + 1)) && (out_valid -> inflight != 16'd0));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R6: assert (!out_valid);
    end
  end

endmodule

bind bsort_top bsort_chk #(.LG_N(LG_N), .KEY_W(KEY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_keys   (in_keys),
  .out_valid (out_valid),
  .out_keys  (out_keys)
);

// File: tb/tb_bsort_top.sv
module tb_bsort_top;
  localparam int LG  = 4;
  localparam int W   = 32;
  localparam int N   = 1 << LG;
  localparam int NW  = N * W;
  localparam int LAT = LG * (LG + 1) / 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [NW-1:0] in_keys;
  logic          out_valid;
  logic [NW-1:0] out_keys;

  int n_cmp = 0;
  int n_bad = 0;
  int tick  = 0;
  bit done  = 0;

  logic [NW-1:0] exp_q[$];
  int            due_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  bsort_top #(.LG_N(LG), .KEY_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_keys(in_keys),
    .out_valid(out_valid), .out_keys(out_keys)
  );

  function automatic logic [NW-1:0] ref_sort(input logic [NW-1:0] v);
    logic [W-1:0] a [N];
    logic [W-1:0] x;
    logic [NW-1:0] r;
    for (int i = 0; i < N; i++) a[i] = v[W*(N-1-i) +: W];
    for (int i = 1; i < N; i++) begin
      x = a[i];
      for (int j = i; j >= 0; j--) begin
        if (j > 0 && a[j-1] > x) a[j] = a[j-1];
        else begin a[j] = x; break; end
      end
    end
    for (int i = 0; i < N; i++) r[W*(N-1-i) +: W] = a[i];
    return r;
  endfunction

  // kind: 0 random, 1 ascending, 2 descending, 3 all equal, 4 duplicates, 5 top-bit mix
  function automatic logic [NW-1:0] mkvec(input int kind);
    logic [NW-1:0] v;
    logic [W-1:0]  k;
    for (int i = 0; i < N; i++) begin
      case (kind)
        1:       k = W'(i * 7 + 3);
        2:       k = W'((N - i) * 5);
        3:       k = 32'hA5A5_0F0F;
        4:       k = W'($urandom % 4);
        5:       k = (i % 2 == 1) ? (32'h8000_0000 | W'(i)) : W'(i * 3);
        default: k = $urandom;
      endcase
      v[W*(N-1-i) +: W] = k;
    end
    return v;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: out_valid=%0b expected %0b (tick %0d)", req, act, exp, tick);
    end
  endtask

  task automatic chk_vec(input string req, input logic [NW-1:0] act, input logic [NW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: out_keys=%h expected %h (tick %0d)", req, act, exp, tick);
    end
  endtask

  // One clock: check what is due now, then drive the next input.
  task automatic step(input logic v, input logic [NW-1:0] d, input string tag);
    @(negedge clk);
    if (due_q.size() > 0 && due_q[0] == tick) begin
      chk_bit("R3 latency", out_valid, 1'b1);
      chk_vec(tag_q[0], out_keys, exp_q[0]);
      void'(due_q.pop_front());
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end else begin
      chk_bit("R5 idle spacing", out_valid, 1'b0);
    end
    in_valid = v;
    in_keys  = d;
    if (v) begin
      exp_q.push_back(ref_sort(d));
      due_q.push_back(tick + LAT);
      tag_q.push_back(tag);
    end
    tick++;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual tick %0d expected below 20000", tick);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b1;
    in_valid = 1'b0;
    in_keys  = '0;
    #1 rst_n = 1'b0;

    // R6: vectors offered during reset never produce output
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk_bit("R6 reset", out_valid, 1'b0);
      in_valid = 1'b1;
      in_keys  = mkvec(0);
    end
    @(negedge clk);
    chk_bit("R6 reset", out_valid, 1'b0);
    in_valid = 1'b0;
    rst_n    = 1'b1;

    // Single vector then idle: exact latency, ordering, conservation
    step(1'b1, mkvec(0), "R1 R2 single random");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, "");

    // Structured patterns
    step(1'b1, mkvec(1), "R8 ascending");
    step(1'b1, mkvec(2), "R8 descending");
    step(1'b1, mkvec(3), "R8 all equal");
    step(1'b1, mkvec(4), "R8 duplicates");
    step(1'b1, mkvec(5), "R7 unsigned top bit");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, "");

    // Back-to-back stream
    for (int i = 0; i < 40; i++) step(1'b1, mkvec(i % 6), "R4 stream");

    // Gapped stream with garbage on idle cycles
    for (int i = 0; i < 24; i++) begin
      if (i % 3 == 0) step(1'b0, mkvec(0), "");
      else            step(1'b1, mkvec(i % 6), "R9 gapped");
    end

    for (int i = 0; i < LAT + 3; i++) step(1'b0, mkvec(0), "");

    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R5: %0d results never emerged, expected 0", exp_q.size());
    end

    done = 1;
    summary();
    $finish;
  end

endmodule